// File: doc/BRIEF.md
# Padded Single-Wire Frame Transmitter

This block sends frames onto a shared one-wire bus that several devices use, with a weak pull-down holding the line low when no device drives it. Each byte on the wire starts with a synchronization pad: a high interval longer than one bit, then one standard low bit. After the pad come the eight data bits, least significant first. A receiver can then resynchronise on every byte even when its clock is poor. A frame opens with three pads in a row, which mark the frame start, and each data byte follows with its own pad.

When a frame is requested, the block listens before it drives. The line must stay low for longer than one padded byte, plus a random number of whole bit times drawn from an LFSR. Any high level seen during this wait restarts the count and draws a new random delay. While it sends, the block compares the bus with what it drives on the low parts of the waveform. If another device pulls the line high, the block drops the frame. All durations are parameters counted in clock cycles. Data bytes are taken through a valid/ready handshake, and the user marks the final byte with a last flag.

Top module: `padwire_tx`

## Requirements
- R1: After reset `line_oe`, `busy`, `byte_ready`, `done` and `abort` are all 0, so the bus floats.
- R2: After `frame_start`, the block does not drive until the bus has read low for `IDLE_CYC = PAD_CYC + 9*BIT_CYC + 1` cycles plus `k*BIT_CYC` cycles, with 0 <= k <= 2^`BO_W`-1 taken from the LFSR. The first driven cycle comes `IDLE_CYC + k*BIT_CYC + 1` cycles after the `frame_start` cycle.
- R3: A high level on `bus_in` during the wait clears the silence count. The block then drives only after `IDLE_CYC + k*BIT_CYC` cycles, counted from the first low cycle after the bus falls.
- R4: A frame begins with three sync pads. Each pad drives high (`line_out`=1, `line_oe`=1) for `PAD_CYC` cycles and then low for `BIT_CYC` cycles.
- R5: Each data byte is sent as one sync pad followed by its 8 bits, bit 0 first. Each bit holds its value on `line_out` for `BIT_CYC` cycles.
- R6: `byte_ready` is high for exactly the first cycle of each data byte's pad, and a byte is taken when `byte_valid` is also high. The frame ends after a byte taken with `byte_last`=1. In the cycle after that byte's bit 7, `done` is 1 for one cycle, and `line_oe` and `busy` are 0.
- R7: If `byte_valid` is 0 while `byte_ready` is 1, the block raises `abort` for one cycle in the next cycle and releases the bus (`line_oe`=0).
- R8: A collision is `bus_in` reading 1 while the block drives low, from the second cycle of a low segment on. On a collision the block raises `abort` in the next cycle and releases the bus.
- R9: A frame never carries more than `MAX_BYTES` bytes. The byte numbered `MAX_BYTES` ends the frame as if `byte_last` had been set.
- R10: `frame_start` has no effect while `busy` is 1, so no second frame follows the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Request to send one frame |
| byte_valid | input | 1 | A data byte is presented |
| byte_data | input | 8 | Data byte |
| byte_last | input | 1 | The presented byte is the final one of the frame |
| byte_ready | output | 1 | The presented byte is taken in this cycle |
| bus_in | input | 1 | Synchronised level of the bus |
| line_out | output | 1 | Level to drive onto the bus |
| line_oe | output | 1 | Drive enable; 0 lets the bus float to its pull-down |
| busy | output | 1 | A frame request is being handled |
| done | output | 1 | One-cycle pulse when a frame completes |
| abort | output | 1 | One-cycle pulse when a frame is dropped |

## Verification
The bench measures the exact start delay for several frames and for a wait that is interrupted. A gate that counted one cycle too few, ignored the random term, or did not restart on a high level would start at a delay outside the allowed set. Every pad and bit of the waveform is compared cycle by cycle, which catches MSB-first order, a missing third pad or an off-by-one segment length. The bench also drives a collision on a low bit, starves the handshake, sends more bytes than the limit and pulses `frame_start` in mid-frame. A design that ignored the collision, waited for data, overran the limit or queued a second frame would keep driving or stay busy.

// File: rtl/padwire_pkg.sv
package padwire_pkg;

    typedef enum logic [2:0] {
        PW_IDLE,
        PW_WAIT,
        PW_PADH,
        PW_PADL,
        PW_DATA
    } pw_state_e;

    typedef struct packed {
        logic [7:0] bits;
        logic       last;
    } pw_byte_t;

    localparam int PW_INIT_PADS = 3;
    localparam int PW_BYTE_BITS = 8;

    // Silence needed before a frame: strictly longer than one padded byte.
    function automatic int pw_idle_cycles(input int bit_c, input int pad_c);
        return pad_c + bit_c * (1 + PW_BYTE_BITS) + 1;
    endfunction

    // Pad high must exceed one bit and must not be a whole multiple of it.
    function automatic bit pw_ratio_ok(input int bit_c, input int pad_c);
        return (bit_c > 0) && (pad_c > bit_c) && ((pad_c % bit_c) != 0);
    endfunction

    function automatic logic [15:0] pw_lfsr_next(input logic [15:0] q);
        return {q[14:0], q[15] ^ q[13] ^ q[12] ^ q[10]};
    endfunction

endpackage

// File: rtl/padwire_lfsr.sv
module padwire_lfsr
    import padwire_pkg::*;
#(
    parameter logic [15:0] SEED = 16'hACE1,
    parameter int          BO_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    output logic [BO_W-1:0] rnd_o
);
    logic [15:0] q_r;

    always_ff @(posedge clk) begin
        if (rst) q_r <= SEED;
        else     q_r <= pw_lfsr_next(q_r);
    end

    assign rnd_o = q_r[BO_W-1:0];

    AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (rst)
        q_r != 16'h0);  // R2
endmodule

// File: rtl/padwire_idle_gate.sv
module padwire_idle_gate
    import padwire_pkg::*;
#(
    parameter int BIT_CYC = 10,
    parameter int PAD_CYC = 28,
    parameter int BO_W    = 2,
    parameter int CNT_W   = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            arm_i,
    input  logic            bus_i,
    input  logic [BO_W-1:0] rnd_i,
    output logic            clear_o
);
    localparam int IDLE_CYC = pw_idle_cycles(BIT_CYC, PAD_CYC);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] target_q;

    assign clear_o = arm_i && !bus_i && (cnt_q == target_q - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            target_q <= CNT_W'(IDLE_CYC);
        end else if (!arm_i || bus_i) begin
            cnt_q    <= '0;
            target_q <= CNT_W'(IDLE_CYC) + CNT_W'(rnd_i) * CNT_W'(BIT_CYC);
        end else if (!clear_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_GATE_LONG: assert property (@(posedge clk) disable iff (rst)
        clear_o |-> cnt_q >= CNT_W'(IDLE_CYC - 1));  // R2
    AST_GATE_QUIET: assert property (@(posedge clk) disable iff (rst)
        clear_o |-> $past(!bus_i));  // R3
endmodule

// File: rtl/padwire_framer.sv
module padwire_framer
    import padwire_pkg::*;
#(
    parameter int BIT_CYC   = 10,
    parameter int PAD_CYC   = 28,
    parameter int MAX_BYTES = 65535,
    parameter int SEG_W     = 8,
    parameter int BCNT_W    = 17
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       clear_i,
    output logic       arm_o,
    input  logic       byte_valid_i,
    input  logic [7:0] byte_data_i,
    input  logic       byte_last_i,
    output logic       byte_ready_o,
    input  logic       bus_i,
    output logic       line_out_o,
    output logic       line_oe_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       abort_o
);
    pw_state_e         st_q;
    logic [SEG_W-1:0]  cyc_q;
    logic [2:0]        bit_q;
    logic [1:0]        pad_q;
    logic              init_q;
    pw_byte_t          cur_q;
    logic [BCNT_W-1:0] nbytes_q;
    logic              low_q;
    logic              done_q;
    logic              abort_q;

    logic drive_low, collide, pad_end, bit_end, final_byte;

    assign line_oe_o    = (st_q == PW_PADH) || (st_q == PW_PADL) || (st_q == PW_DATA);
    assign line_out_o   = (st_q == PW_PADH) || ((st_q == PW_DATA) && cur_q.bits[0]);
    assign drive_low    = line_oe_o && !line_out_o;
    assign collide      = low_q && drive_low && bus_i;
    assign byte_ready_o = (st_q == PW_PADH) && !init_q && (cyc_q == '0);
    assign pad_end      = (cyc_q == SEG_W'(PAD_CYC - 1));
    assign bit_end      = (cyc_q == SEG_W'(BIT_CYC - 1));
    assign final_byte   = byte_last_i || (nbytes_q == BCNT_W'(MAX_BYTES - 1));
    assign arm_o        = (st_q == PW_WAIT);
    assign busy_o       = (st_q != PW_IDLE);
    assign done_o       = done_q;
    assign abort_o      = abort_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= PW_IDLE;
            cyc_q    <= '0;
            bit_q    <= '0;
            pad_q    <= '0;
            init_q   <= 1'b0;
            cur_q    <= '0;
            nbytes_q <= '0;
            low_q    <= 1'b0;
            done_q   <= 1'b0;
            abort_q  <= 1'b0;
        end else begin
            done_q  <= 1'b0;
            abort_q <= 1'b0;
            low_q   <= drive_low;
            unique case (st_q)
                PW_IDLE: if (start_i) st_q <= PW_WAIT;
                PW_WAIT: if (clear_i) begin
                    st_q     <= PW_PADH;
                    cyc_q    <= '0;
                    init_q   <= 1'b1;
                    pad_q    <= '0;
                    nbytes_q <= '0;
                end
                PW_PADH: begin
                    if (byte_ready_o && !byte_valid_i) begin
                        abort_q <= 1'b1;
                        st_q    <= PW_IDLE;
                    end else begin
                        if (byte_ready_o) begin
                            cur_q.bits <= byte_data_i;
                            cur_q.last <= final_byte;
                            nbytes_q   <= nbytes_q + 1'b1;
                        end
                        if (pad_end) begin
                            st_q  <= PW_PADL;
                            cyc_q <= '0;
                        end else begin
                            cyc_q <= cyc_q + 1'b1;
                        end
                    end
                end
                PW_PADL: begin
                    if (collide) begin
                        abort_q <= 1'b1;
                        st_q    <= PW_IDLE;
                    end else if (bit_end) begin
                        cyc_q <= '0;
                        bit_q <= '0;
                        if (init_q) begin
                            st_q <= PW_PADH;
                            if (pad_q == 2'(PW_INIT_PADS - 1)) init_q <= 1'b0;
                            else                               pad_q  <= pad_q + 1'b1;
                        end else begin
                            st_q <= PW_DATA;
                        end
                    end else begin
                        cyc_q <= cyc_q + 1'b1;
                    end
                end
                PW_DATA: begin
                    if (collide) begin
                        abort_q <= 1'b1;
                        st_q    <= PW_IDLE;
                    end else if (bit_end) begin
                        cyc_q      <= '0;
                        cur_q.bits <= {1'b0, cur_q.bits[7:1]};
                        if (bit_q == 3'(PW_BYTE_BITS - 1)) begin
                            if (cur_q.last) begin
                                done_q <= 1'b1;
                                st_q   <= PW_IDLE;
                            end else begin
                                st_q <= PW_PADH;
                            end
                        end else begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end else begin
                        cyc_q <= cyc_q + 1'b1;
                    end
                end
                default: st_q <= PW_IDLE;
            endcase
        end
    end

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
        byte_ready_o |=> !byte_ready_o);  // R6
    AST_DONE_FREE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!line_oe_o && !busy_o));  // R6
    AST_UNDERRUN: assert property (@(posedge clk) disable iff (rst)
        (byte_ready_o && !byte_valid_i) |=> (abort_o && !line_oe_o));  // R7
    AST_COLLIDE_STOP: assert property (@(posedge clk) disable iff (rst)
        collide |=> (abort_o && !line_oe_o));  // R8
    AST_BIT_STABLE: assert property (@(posedge clk) disable iff (rst)
        (st_q == PW_DATA && cyc_q != '0) |-> $stable(line_out_o));  // R5
    AST_MAX_BYTES: assert property (@(posedge clk) disable iff (rst)
        nbytes_q <= BCNT_W'(MAX_BYTES));  // R9
endmodule

// File: rtl/padwire_tx.sv
module padwire_tx
    import padwire_pkg::*;
#(
    parameter int          BIT_CYC   = 10000,
    parameter int          PAD_CYC   = 28000,
    parameter int          BO_W      = 3,
    parameter int          MAX_BYTES = 65535,
    parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_start,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    input  logic       byte_last,
    output logic       byte_ready,
    input  logic       bus_in,
    output logic       line_out,
    output logic       line_oe,
    output logic       busy,
    output logic       done,
    output logic       abort
);
    localparam int IDLE_CYC = pw_idle_cycles(BIT_CYC, PAD_CYC);
    localparam int TGT_MAX  = IDLE_CYC + ((1 << BO_W) - 1) * BIT_CYC;
    localparam int CNT_W    = $clog2(TGT_MAX + 1);
    localparam int SEG_W    = $clog2(PAD_CYC + 1);
    localparam int BCNT_W   = $clog2(MAX_BYTES + 1);

    if (!pw_ratio_ok(BIT_CYC, PAD_CYC)) begin : g_bad_ratio
        $error("pad high must exceed one bit and not be a whole multiple of it");
    end
    if (BO_W < 1 || BO_W > 16 || MAX_BYTES < 1 || MAX_BYTES > 65535) begin : g_bad_size
        $error("back-off width or frame byte limit out of range");
    end

    logic [BO_W-1:0] rnd;
    logic            arm;
    logic            clear;

    padwire_lfsr #(.SEED(LFSR_SEED), .BO_W(BO_W)) u_lfsr (
        .clk(clk), .rst(rst), .rnd_o(rnd)
    );

    padwire_idle_gate #(
        .BIT_CYC(BIT_CYC), .PAD_CYC(PAD_CYC), .BO_W(BO_W), .CNT_W(CNT_W)
    ) u_gate (
        .clk(clk), .rst(rst), .arm_i(arm), .bus_i(bus_in), .rnd_i(rnd), .clear_o(clear)
    );

    padwire_framer #(
        .BIT_CYC(BIT_CYC), .PAD_CYC(PAD_CYC), .MAX_BYTES(MAX_BYTES),
        .SEG_W(SEG_W), .BCNT_W(BCNT_W)
    ) u_framer (
        .clk(clk), .rst(rst), .start_i(frame_start), .clear_i(clear), .arm_o(arm),
        .byte_valid_i(byte_valid), .byte_data_i(byte_data), .byte_last_i(byte_last),
        .byte_ready_o(byte_ready), .bus_i(bus_in), .line_out_o(line_out),
        .line_oe_o(line_oe), .busy_o(busy), .done_o(done), .abort_o(abort)
    );
endmodule

// File: tb/tb_padwire_tx.sv
`timescale 1ns/1ps
module tb_padwire_tx;
    localparam int BIT  = 10;
    localparam int PAD  = 28;
    localparam int BOW  = 2;
    localparam int MAXB = 3;
    localparam int IDLE = PAD + 9 * BIT + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_start = 1'b0;
    logic byte_valid, byte_last, byte_ready;
    logic [7:0] byte_data;
    logic bus_in, line_out, line_oe, busy, done, abort;
    logic ext_hi = 1'b0;

    logic [7:0] fmem [0:7];
    int  fn = 0;
    int  fidx = 0;
    logic feed_en = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    assign bus_in     = (line_oe & line_out) | ext_hi;
    assign byte_valid = feed_en && (fidx < fn);
    assign byte_data  = fmem[fidx[2:0]];
    assign byte_last  = (fidx == fn - 1);

    always @(posedge clk) if (byte_ready && byte_valid) fidx <= fidx + 1;

    padwire_tx #(.BIT_CYC(BIT), .PAD_CYC(PAD), .BO_W(BOW), .MAX_BYTES(MAXB)) dut (
        .clk(clk), .rst(rst), .frame_start(frame_start), .byte_valid(byte_valid),
        .byte_data(byte_data), .byte_last(byte_last), .byte_ready(byte_ready),
        .bus_in(bus_in), .line_out(line_out), .line_oe(line_oe), .busy(busy),
        .done(done), .abort(abort)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic expect_seg(input logic val, input int n, input string req);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            if (!(line_oe && line_out == val)) bad++;
            @(negedge clk);
        end
        check(bad == 0, req, bad, 0);
    endtask

    task automatic expect_byte(input logic [7:0] b);
        expect_seg(1'b1, PAD, "R5 pad high");
        expect_seg(1'b0, BIT, "R5 pad low");
        for (int i = 0; i < 8; i++) expect_seg(b[i], BIT, "R5 data bit");
    endtask

    task automatic expect_init();
        for (int p = 0; p < 3; p++) begin
            expect_seg(1'b1, PAD, "R4 init pad high");
            expect_seg(1'b0, BIT, "R4 init pad low");
        end
    endtask

    // Pulse start and check the start delay (R2).
    task automatic kick_and_wait();
        int d;
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        d = 1;
        while (!line_oe && d < 2000) begin
            @(negedge clk);
            d++;
        end
        check((d - 1 - IDLE) >= 0 && (d - 1 - IDLE) <= 3 * BIT && ((d - 1 - IDLE) % BIT) == 0,
              "R2 start delay", d - 1, IDLE);
    endtask

    task automatic t_reset();
        check(!line_oe && !busy && !byte_ready && !done && !abort, "R1 reset outputs",
              {line_oe, busy, byte_ready, done, abort}, 0);
    endtask

    task automatic run_frame(input int n, input int nexp, input bit poke);
        fidx = 0;
        fn = n;
        feed_en = 1'b1;
        kick_and_wait();
        expect_init();
        for (int k = 0; k < nexp; k++) begin
            if (poke && k == 0) begin
                frame_start = 1'b1;
                fork begin @(negedge clk); frame_start = 1'b0; end join_none
            end
            expect_byte(fmem[k]);
        end
        check(done && !line_oe && !busy, nexp < n ? "R9 limit ends frame" : "R6 done after last",
              {done, line_oe, busy}, 4);
        feed_en = 1'b0;
        if (poke) begin
            int b = 0;
            for (int i = 0; i < 300; i++) begin
                if (busy || line_oe) b++;
                @(negedge clk);
            end
            check(b == 0, "R10 start while busy ignored", b, 0);
        end else begin
            repeat (5) @(negedge clk);
        end
    endtask

    task automatic t_defer();
        int d;
        fidx = 0;
        fn = 1;
        fmem[0] = 8'h5A;
        feed_en = 1'b1;
        ext_hi = 1'b1;
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        for (int i = 0; i < 150; i++) begin
            if (i == 140) ext_hi = 1'b0;
            else if (i > 130 && i < 140) ext_hi = 1'b1;
            @(negedge clk);
        end
        // Released 10 negedges ago; the count restarts from there.
        ext_hi = 1'b0;
        d = 10;
        while (!line_oe && d < 2000) begin
            @(negedge clk);
            d++;
        end
        check((d - IDLE) >= 0 && (d - IDLE) <= 3 * BIT && ((d - IDLE) % BIT) == 0,
              "R3 delay after bus release", d, IDLE);
        expect_init();
        expect_byte(8'h5A);
        check(done && !line_oe, "R6 done after deferred frame", {done, line_oe}, 2);
        feed_en = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_underrun();
        feed_en = 1'b0;
        kick_and_wait();
        expect_init();
        check(byte_ready == 1'b1, "R6 ready at byte pad", byte_ready, 1);
        @(negedge clk);
        check(abort && !line_oe && !busy, "R7 underrun aborts", {abort, line_oe, busy}, 4);
        repeat (5) @(negedge clk);
    endtask

    task automatic t_collision();
        int n = 0;
        fidx = 0;
        fn = 1;
        fmem[0] = 8'h00;
        feed_en = 1'b1;
        kick_and_wait();
        expect_seg(1'b1, PAD, "R4 first pad high");
        ext_hi = 1'b1;
        while (!abort && n < 6) begin
            @(negedge clk);
            n++;
        end
        check(n == 2, "R8 collision abort timing", n, 2);
        check(!line_oe, "R8 bus released on collision", line_oe, 0);
        ext_hi = 1'b0;
        feed_en = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();

        fmem[0] = 8'hA5;
        run_frame(1, 1, 1'b0);
        fmem[0] = 8'h01;
        run_frame(1, 1, 1'b0);
        fmem[0] = 8'h80;
        run_frame(1, 1, 1'b0);

        fmem[0] = 8'h00; fmem[1] = 8'hFF; fmem[2] = 8'h3C;
        run_frame(3, 3, 1'b1);

        fmem[0] = 8'h12; fmem[1] = 8'h34; fmem[2] = 8'h56; fmem[3] = 8'h78; fmem[4] = 8'h9A;
        run_frame(5, MAXB, 1'b0);

        t_defer();
        t_underrun();
        t_collision();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule